// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Unit

This unit is the protection core of a serial non-volatile memory. It holds the status byte, which carries a write-enable latch, a two-bit block-protect level, a protect-pin enable bit and a mirror of the internal busy flag. The serial front end decodes opcodes and tells this unit, one pulse at a time, when an instruction has completed. The unit answers with two combinational permits: one that says whether an array write to the presented address may be committed, and one that says whether a status write may be committed.

The write-enable latch can only be armed by a completed write-enable instruction, whose event the front end raises when chip select returns high after all eight opcode bits. Every committed write disarms it. The protect level fences off the top quarter, the top half or the whole array. The external protect pin locks the non-volatile status bits, but only while the pin-enable bit is set. The status byte is available on every cycle, also while an internal write runs.

Top module: `stsprot_top`

## Requirements
- R1: After reset the status byte reads 0x00 (with busy low), and both permits are low.
- R2: The status byte carries the pin-enable bit at bit 7, zeros at bits 6 to 4, the protect level at bits 3:2, the write-enable latch at bit 1 and the live busy input at bit 0; it is valid in every cycle, including while busy is high.
- R3: A write-enable event sets the latch in the next cycle, whatever the protect level, pin or busy state.
- R4: A write-disable event clears the latch in the next cycle.
- R5: A status-write event taken while the status permit is high loads bits 7, 3 and 2 from the data byte, ignores its other bits and clears the latch.
- R6: With the latch clear, both permits are low, and a status-write event leaves the status byte unchanged.
- R7: When the pin-enable bit is 1 and the protect pin is low, the status permit is low and a status-write event changes nothing (latch included); with the pin high, or the enable bit 0, the status permit follows the latch.
- R8: Protect level 0 guards no address, level 1 guards 0x1800 to 0x1FFF, level 2 guards 0x1000 to 0x1FFF and level 3 guards the whole array.
- R9: The array permit is high only when the latch is set, busy is low and the address is outside the guarded range; a write-done event taken while the permit is high clears the latch.
- R10: A write-done event taken while the array permit is low leaves the latch set.
- R11: While busy is high, both permits are low.
- R12: When a clearing event and a write-enable event arrive in the same cycle, the latch ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, also the power-on clear |
| wrenDone | input | 1 | Pulse: write-enable opcode completed and chip select rose |
| wrdiDone | input | 1 | Pulse: write-disable opcode completed |
| wrsrDone | input | 1 | Pulse: status-write sequence completed with its data byte |
| wrsrData | input | 8 | Data byte of the status write |
| arrayWriteDone | input | 1 | Pulse: array write sequence closed at a byte boundary |
| wrAddr | input | ADDR_W | Target address of the array write |
| wpN | input | 1 | Protect pin, low means protect |
| busy | input | 1 | Internal write cycle in progress |
| statusByte | output | 8 | Status byte for the read-status path |
| arrayWrOk | output | 1 | Array write may be committed |
| statusWrOk | output | 1 | Status write may be committed |

## Verification
The assertions assume the front end raises each event for exactly one cycle and holds wrAddr and wrsrData steady in that cycle; they also rely on the latch and protection bits moving only on those events. Only the same-cycle enable/clear collision of R12 is treated as legal overlap. The bench drives every input at the falling edge, gives each event a single-cycle pulse and reads outputs at the next falling edge, so all stimulus stays inside those assumptions.

// File: rtl/stsprot_pkg.sv
package stsprot_pkg;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadNv;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'd0,
    LVL_QUARTER = 2'd1,
    LVL_HALF    = 2'd2,
    LVL_ALL     = 2'd3
  } protLevel_t;

  localparam logic [7:0] NV_MASK = 8'b1000_1100;
  localparam int PE_BIT  = 7;
  localparam int LVL_LO  = 2;
  localparam int WEL_BIT = 1;
  localparam int BSY_BIT = 0;

endpackage

// File: rtl/stsprot_regs.sv
module stsprot_regs
  import stsprot_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [7:0]        wrsrData,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              busy,
  output logic [7:0]        statusByte,
  output logic              wel,
  output logic              pinEnable,
  output logic              addrGuarded
);

  localparam int          CMP_W        = ADDR_W + 1;
  localparam int unsigned DEPTH        = 1 << ADDR_W;
  localparam int unsigned HALF_BASE    = DEPTH / 2;
  localparam int unsigned QUARTER_BASE = DEPTH - DEPTH / 4;

  logic [7:0]   nvReg;
  logic         welReg;
  protLevel_t   level;
  logic [CMP_W-1:0] guardBase;
  logic [CMP_W-1:0] addrExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      welReg <= 1'b0;
    end else if (strobe.clrWel) begin
      welReg <= 1'b0;
    end else if (strobe.setWel) begin
      welReg <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nvReg <= 8'h00;
    end else if (strobe.loadNv) begin
      nvReg <= wrsrData & NV_MASK;
    end
  end

  assign level = protLevel_t'(nvReg[LVL_LO+1:LVL_LO]);

  always_comb begin
    unique case (level)
      LVL_QUARTER: guardBase = CMP_W'(QUARTER_BASE);
      LVL_HALF:    guardBase = CMP_W'(HALF_BASE);
      LVL_ALL:     guardBase = '0;
      default:     guardBase = CMP_W'(DEPTH);
    endcase
  end

  assign addrExt     = {1'b0, wrAddr};
  assign addrGuarded = (addrExt >= guardBase);

  assign wel        = welReg;
  assign pinEnable  = nvReg[PE_BIT];
  assign statusByte = (nvReg & NV_MASK) | {6'b0, welReg, busy};

  p_load_keeps_unused_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadNv |=> (statusByte[6:4] == 3'b000));

  p_nv_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadNv |=> $stable(nvReg));

endmodule

// File: rtl/stsprot_ctl.sv
module stsprot_ctl
  import stsprot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrenDone,
  input  logic       wrdiDone,
  input  logic       wrsrDone,
  input  logic       arrayWriteDone,
  input  logic       wpN,
  input  logic       busy,
  input  logic       wel,
  input  logic       pinEnable,
  input  logic       addrGuarded,
  output ctlStrobe_t strobe,
  output logic       arrayWrOk,
  output logic       statusWrOk
);

  logic hwLock;
  logic wrsrTaken;
  logic arrayTaken;

  assign hwLock     = pinEnable && !wpN;
  assign arrayWrOk  = wel && !busy && !addrGuarded;
  assign statusWrOk = wel && !busy && !hwLock;

  assign wrsrTaken  = wrsrDone && statusWrOk;
  assign arrayTaken = arrayWriteDone && arrayWrOk;

  always_comb begin
    strobe        = '0;
    strobe.setWel = wrenDone;
    strobe.clrWel = wrdiDone || wrsrTaken || arrayTaken;
    strobe.loadNv = wrsrTaken;
  end

  p_wren_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrenDone && !wrdiDone && !wrsrDone && !arrayWriteDone) |=> wel);

  p_wrdi_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrdiDone |=> !wel);

  p_collide_clear_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wrenDone && wrdiDone) |=> !wel);

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(arrayWrOk || statusWrOk));

endmodule

// File: rtl/stsprot_top.sv
module stsprot_top
  import stsprot_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrenDone,
  input  logic              wrdiDone,
  input  logic              wrsrDone,
  input  logic [7:0]        wrsrData,
  input  logic              arrayWriteDone,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wpN,
  input  logic              busy,
  output logic [7:0]        statusByte,
  output logic              arrayWrOk,
  output logic              statusWrOk
);

  ctlStrobe_t strobe;
  logic       wel;
  logic       pinEnable;
  logic       addrGuarded;

  stsprot_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrsrData    (wrsrData),
    .wrAddr      (wrAddr),
    .busy        (busy),
    .statusByte  (statusByte),
    .wel         (wel),
    .pinEnable   (pinEnable),
    .addrGuarded (addrGuarded)
  );

  stsprot_ctl u_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .wrenDone       (wrenDone),
    .wrdiDone       (wrdiDone),
    .wrsrDone       (wrsrDone),
    .arrayWriteDone (arrayWriteDone),
    .wpN            (wpN),
    .busy           (busy),
    .wel            (wel),
    .pinEnable      (pinEnable),
    .addrGuarded    (addrGuarded),
    .strobe         (strobe),
    .arrayWrOk      (arrayWrOk),
    .statusWrOk     (statusWrOk)
  );

  p_pin_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrsrDone && statusByte[PE_BIT] && !wpN)
      |=> ($stable(statusByte[7:2]) && $stable(statusByte[WEL_BIT])));

  p_no_latch_no_permit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[WEL_BIT] |-> !(arrayWrOk || statusWrOk));

  p_commit_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (arrayWriteDone && arrayWrOk) |=> !statusByte[WEL_BIT]);

  p_blocked_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (arrayWriteDone && !arrayWrOk && statusByte[WEL_BIT] && !wrdiDone && !wrsrDone)
      |=> statusByte[WEL_BIT]);

  p_busy_mirror_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[BSY_BIT] == busy);

endmodule

// File: tb/stsprot_top_bench.sv
module stsprot_top_bench;

  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrenDone = 1'b0;
  logic              wrdiDone = 1'b0;
  logic              wrsrDone = 1'b0;
  logic [7:0]        wrsrData = 8'h00;
  logic              arrayWriteDone = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic              wpN = 1'b1;
  logic              busy = 1'b0;
  logic [7:0]        statusByte;
  logic              arrayWrOk;
  logic              statusWrOk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stsprot_top #(.ADDR_W(ADDR_W)) u_stsprot_top (
    .clk(clk), .rstN(rstN), .wrenDone(wrenDone), .wrdiDone(wrdiDone),
    .wrsrDone(wrsrDone), .wrsrData(wrsrData), .arrayWriteDone(arrayWriteDone),
    .wrAddr(wrAddr), .wpN(wpN), .busy(busy), .statusByte(statusByte),
    .arrayWrOk(arrayWrOk), .statusWrOk(statusWrOk)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mask bits: 0 wren, 1 wrdi, 2 wrsr, 3 array write done
  task automatic pulse(input logic [3:0] mask, input logic [7:0] data);
    @(negedge clk);
    wrenDone       = mask[0];
    wrdiDone       = mask[1];
    wrsrDone       = mask[2];
    arrayWriteDone = mask[3];
    wrsrData       = data;
    @(negedge clk);
    wrenDone = 1'b0; wrdiDone = 1'b0; wrsrDone = 1'b0; arrayWriteDone = 1'b0;
    #0.5;
  endtask

  task automatic setStatus(input logic [7:0] data);
    pulse(4'b0001, 8'h00);
    pulse(4'b0100, data);
  endtask

  task automatic t_reset();
    #0.5;
    chk("R1 status", {8'h0, statusByte}, 16'h0000);
    chk("R1 permits", {14'h0, arrayWrOk, statusWrOk}, 16'h0000);
  endtask

  task automatic t_wren_wrdi();
    pulse(4'b0001, 8'h00);
    chk("R3 latch set", {8'h0, statusByte}, 16'h0002);
    chk("R3 status permit", {15'h0, statusWrOk}, 16'h0001);
    pulse(4'b0010, 8'h00);
    chk("R4 latch clear", {8'h0, statusByte}, 16'h0000);
  endtask

  task automatic t_wrsr_no_latch();
    pulse(4'b0100, 8'hFF);
    chk("R6 ignored wrsr", {8'h0, statusByte}, 16'h0000);
    chk("R6 permits", {14'h0, arrayWrOk, statusWrOk}, 16'h0000);
  endtask

  task automatic t_wrsr_accept();
    setStatus(8'h7F);
    chk("R5 masked load", {8'h0, statusByte}, 16'h000C);
    setStatus(8'h00);
    chk("R2 layout cleared", {8'h0, statusByte}, 16'h0000);
  endtask

  task automatic t_map();
    logic [ADDR_W-1:0] probes [6] = '{13'h0000, 13'h0FFF, 13'h1000, 13'h17FF, 13'h1800, 13'h1FFF};
    for (int lvl = 0; lvl < 4; lvl++) begin
      setStatus(8'(lvl << 2));
      pulse(4'b0001, 8'h00);
      for (int p = 0; p < 6; p++) begin
        logic expOk;
        case (lvl)
          0: expOk = 1'b1;
          1: expOk = probes[p] < 13'h1800;
          2: expOk = probes[p] < 13'h1000;
          default: expOk = 1'b0;
        endcase
        @(negedge clk);
        wrAddr = probes[p];
        #0.5;
        chk($sformatf("R8 lvl%0d addr %h", lvl, probes[p]), {15'h0, arrayWrOk}, {15'h0, expOk});
      end
    end
    setStatus(8'h00);
  endtask

  task automatic t_pin_lock();
    wpN = 1'b1;
    setStatus(8'h80);
    chk("R7 enable bit loaded", {8'h0, statusByte}, 16'h0080);
    pulse(4'b0001, 8'h00);
    @(negedge clk); wpN = 1'b0; #0.5;
    chk("R7 locked permit", {15'h0, statusWrOk}, 16'h0000);
    pulse(4'b0100, 8'h0C);
    chk("R7 locked no change", {8'h0, statusByte}, 16'h0082);
    pulse(4'b0010, 8'h00);
    pulse(4'b0001, 8'h00);
    chk("R3 latch set while locked", {8'h0, statusByte}, 16'h0082);
    @(negedge clk); wpN = 1'b1; #0.5;
    chk("R7 pin high permit", {15'h0, statusWrOk}, 16'h0001);
    pulse(4'b0100, 8'h00);
    chk("R7 unlock write", {8'h0, statusByte}, 16'h0000);
    pulse(4'b0001, 8'h00);
    @(negedge clk); wpN = 1'b0; #0.5;
    chk("R7 enable bit 0 ignores pin", {15'h0, statusWrOk}, 16'h0001);
    @(negedge clk); wpN = 1'b1;
    pulse(4'b0010, 8'h00);
  endtask

  task automatic t_busy();
    pulse(4'b0001, 8'h00);
    @(negedge clk); busy = 1'b1; wrAddr = 13'h0010; #0.5;
    chk("R2 busy visible", {8'h0, statusByte}, 16'h0003);
    chk("R11 permits low", {14'h0, arrayWrOk, statusWrOk}, 16'h0000);
    pulse(4'b0010, 8'h00);
    chk("R4 wrdi while busy", {8'h0, statusByte}, 16'h0001);
    @(negedge clk); busy = 1'b0; #0.5;
  endtask

  task automatic t_array_commit();
    pulse(4'b0001, 8'h00);
    @(negedge clk); wrAddr = 13'h0123; #0.5;
    chk("R9 permit", {15'h0, arrayWrOk}, 16'h0001);
    pulse(4'b1000, 8'h00);
    chk("R9 commit clears", {8'h0, statusByte}, 16'h0000);
    setStatus(8'h04);
    pulse(4'b0001, 8'h00);
    @(negedge clk); wrAddr = 13'h1900; #0.5;
    chk("R10 guarded permit", {15'h0, arrayWrOk}, 16'h0000);
    pulse(4'b1000, 8'h00);
    chk("R10 latch kept", {8'h0, statusByte}, 16'h0006);
    setStatus(8'h00);
  endtask

  task automatic t_collide();
    pulse(4'b0011, 8'h00);
    chk("R12 wren+wrdi", {8'h0, statusByte}, 16'h0000);
    pulse(4'b0001, 8'h00);
    @(negedge clk); wrAddr = 13'h0001;
    pulse(4'b1001, 8'h00);
    chk("R12 wren+commit", {8'h0, statusByte}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_wren_wrdi();
    t_wrsr_no_latch();
    t_wrsr_accept();
    t_map();
    t_pin_lock();
    t_busy();
    t_array_commit();
    t_collide();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule